// File: doc/BRIEF.md
# Flash Write-Cycle Protection Gate

This block stands between the synchronised control strobes of a parallel NOR-style flash port and the command register behind it. On every clock edge it samples the active-low chip-enable, write-enable and output-enable levels and decides whether the bus is running a genuine write. When write-enable rises at the end of a write that was properly qualified, it issues a one-clock accept strobe to the command logic. It also reports read cycles and rejects short strobe glitches.

Writes are refused while the supply is unsafe. After reset, and again after any dip of the external supply-good flag, the gate holds a lockout and requests a command-machine reset. The lockout ends only once the flag has stayed high for a set number of clocks. A supply dip that lands inside a write cancels that write.

Top module: `flash_wr_gate`

## Requirements
- R1: A write period is a run of clock edges that each sample `ce_n`=0, `we_n`=0 and `oe_n`=1. `wr_accept` goes high one clock after the first edge that samples `we_n`=1 at the end of such a period, provided `ce_n`=0 and `oe_n`=1 on that same edge.
- R2: Every other strobe combination (`oe_n` low, `ce_n` high, or `we_n` high) produces no `wr_accept`.
- R3: `rd_cycle` is high exactly when `ce_n` and `oe_n` are both low, whatever `we_n` is. With all three low the cycle is a read, and no accept follows it.
- R4: A write period shorter than `GLITCH_CYC` consecutive qualifying samples is ignored. A period of exactly `GLITCH_CYC` samples or longer is accepted.
- R5: `wr_accept` lasts one clock and fires at most once per write-enable low period, however long that period is.
- R6: If `oe_n` falls or `ce_n` rises while `we_n` is still low, the period is cancelled. Counting restarts from zero when the pins qualify again.
- R7: After reset, `cmd_reset_req` stays high and all writes are ignored until `vdd_ok` has been sampled high on `PWRUP_CYC` consecutive edges.
- R8: When an edge samples `vdd_ok` low, `cmd_reset_req` is high from the next clock, writes are ignored, and the `PWRUP_CYC` lockout starts over.
- R9: If `vdd_ok` drops during a write period, including on the edge that samples `we_n` rising, no accept is produced for that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Synchronised chip-enable, active low |
| we_n | input | 1 | Synchronised write-enable, active low |
| oe_n | input | 1 | Synchronised output-enable, active low |
| vdd_ok | input | 1 | Supply-good flag from the external comparator |
| wr_accept | output | 1 | One-clock command-accept strobe |
| rd_cycle | output | 1 | Read cycle indicator |
| cmd_reset_req | output | 1 | Reset request to the command state machine |

## Verification
The two functions that can collide are write completion and the low-supply lockout. Both can be triggered by the same clock edge, when that edge samples `we_n` rising and `vdd_ok` falling together. The bench produces this by changing both inputs on one falling clock edge after a fully qualified write period. The result is correct when the scoreboard counts zero accept pulses for that transaction and `cmd_reset_req` is high on the following clock. A second case drops the supply for a single clock in the middle of the low period. Recovery is checked as well: a write is refused during the restarted lockout and accepted after it ends.

// File: rtl/flash_wr_gate.sv
module flash_wr_gate #(
  parameter int GLITCH_CYC = 3,
  parameter int PWRUP_CYC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic vdd_ok,
  output logic wr_accept,
  output logic rd_cycle,
  output logic cmd_reset_req
);
  localparam int LW = $clog2(GLITCH_CYC + 1);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam logic [LW-1:0] LMAX = LW'(GLITCH_CYC);
  localparam logic [PW-1:0] PMAX = PW'(PWRUP_CYC);

  logic [LW-1:0] low_cnt;
  logic [PW-1:0] pu_cnt;
  logic          unlocked, wr_lvl, end_ok;

  assign unlocked      = (pu_cnt == PMAX);
  assign wr_lvl        = !ce_n && !we_n && oe_n;
  assign end_ok        = !ce_n && we_n && oe_n;
  assign rd_cycle      = !ce_n && !oe_n;
  assign cmd_reset_req = !unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pu_cnt <= '0;
    else if (!vdd_ok)     pu_cnt <= '0;
    else if (!unlocked)   pu_cnt <= pu_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                low_cnt <= '0;
    else if (!vdd_ok || !unlocked || !wr_lvl)  low_cnt <= '0;
    else if (low_cnt != LMAX)                  low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_accept <= 1'b0;
    else        wr_accept <= vdd_ok && unlocked && end_ok && (low_cnt == LMAX);
  end

  AST_ACC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_accept); // R5
  AST_ACC_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> $past(we_n) && $past(!ce_n) && $past(oe_n)); // R1
  AST_ACC_SUPPLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> $past(vdd_ok) && !cmd_reset_req); // R9
  AST_LOW_SUPPLY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_ok |=> cmd_reset_req); // R8
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cycle |=> !wr_accept); // R3
  AST_LOCKED_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset_req |=> !wr_accept); // R7
endmodule

// File: tb/flash_wr_gate_tb.sv
module flash_wr_gate_tb_top;
  localparam int GL = 3;
  localparam int PU = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vdd_ok = 1'b1;
  logic wr_accept, rd_cycle, cmd_reset_req;

  int checks = 0, errors = 0, seen = 0;
  bit close_req = 1'b0, done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  flash_wr_gate #(.GLITCH_CYC(GL), .PWRUP_CYC(PU)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .vdd_ok(vdd_ok), .wr_accept(wr_accept), .rd_cycle(rd_cycle),
    .cmd_reset_req(cmd_reset_req));

  function automatic void chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  initial begin
    forever begin
      @(negedge clk); #1;
      if (wr_accept) seen++;
      if (close_req) begin
        chk(seen, exp_q.pop_front(), tag_q.pop_front());
        seen = 0;
        close_req = 1'b0;
      end
    end
  end

  task automatic close_txn(input int exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    close_req = 1'b1;
    wait (close_req == 1'b0);
    @(negedge clk);
    {ce_n, we_n, oe_n} = 3'b111;
    @(negedge clk);
  endtask

  task automatic strobe_txn(input logic c, input logic w, input logic o,
                            input int hold, input int exp, input string tag);
    @(negedge clk);
    {ce_n, we_n, oe_n} = {c, w, o};
    repeat (hold) @(negedge clk);
    #1 chk(int'(rd_cycle), int'(!c && !o), {tag, " R3 rd_cycle"});
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    close_txn(exp, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(cmd_reset_req), 1, "R7 reset state req");
    chk(int'(wr_accept), 0, "R7 reset state accept");
    rst_n = 1'b1;
    strobe_txn(1'b0, 1'b0, 1'b1, 5, 0, "R7 write in power-up window");
    chk(int'(cmd_reset_req), 1, "R7 req held in window");
    repeat (PU + 2) @(negedge clk);
    chk(int'(cmd_reset_req), 0, "R7 lockout released");

    for (int c = 0; c < 8; c++) begin
      logic [2:0] v = 3'(c);
      strobe_txn(v[2], v[1], v[0], 5, (v == 3'b001) ? 1 : 0,
                 $sformatf("R1 R2 combo ce%0b we%0b oe%0b", v[2], v[1], v[0]));
    end

    strobe_txn(1'b0, 1'b0, 1'b1, 1, 0, "R4 one sample");
    strobe_txn(1'b0, 1'b0, 1'b1, GL - 1, 0, "R4 below threshold");
    strobe_txn(1'b0, 1'b0, 1'b1, GL, 1, "R4 at threshold");
    strobe_txn(1'b0, 1'b0, 1'b1, GL + 1, 1, "R4 above threshold");
    strobe_txn(1'b0, 1'b0, 1'b1, 40, 1, "R5 long low once");

    @(negedge clk); {ce_n, we_n, oe_n} = 3'b001;
    repeat (5) @(negedge clk); oe_n = 1'b0;
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
    repeat (2) @(negedge clk);
    close_txn(0, "R6 oe interrupt");

    @(negedge clk); {ce_n, we_n, oe_n} = 3'b001;
    repeat (5) @(negedge clk); ce_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    repeat (2) @(negedge clk);
    close_txn(0, "R6 ce interrupt");

    @(negedge clk); {ce_n, we_n, oe_n} = 3'b001;
    repeat (5) @(negedge clk); vdd_ok = 1'b0;
    @(negedge clk); #1 chk(int'(cmd_reset_req), 1, "R8 req on supply drop");
    vdd_ok = 1'b1;
    @(negedge clk); we_n = 1'b1;
    repeat (2) @(negedge clk);
    close_txn(0, "R9 drop mid write");
    strobe_txn(1'b0, 1'b0, 1'b1, 4, 0, "R8 lockout restarted");
    repeat (PU + 2) @(negedge clk);
    strobe_txn(1'b0, 1'b0, 1'b1, 4, 1, "R8 recovered after lockout");

    @(negedge clk); {ce_n, we_n, oe_n} = 3'b001;
    repeat (5) @(negedge clk);
    we_n = 1'b1; vdd_ok = 1'b0;
    @(negedge clk); #1 chk(int'(cmd_reset_req), 1, "R9 req same edge");
    @(negedge clk);
    close_txn(0, "R9 drop on rising edge");
    strobe_txn(1'b0, 1'b0, 1'b1, 6, 0, "R8 sustained low supply");
    chk(int'(cmd_reset_req), 1, "R8 req while low");
    vdd_ok = 1'b1;
    repeat (PU + 2) @(negedge clk);
    strobe_txn(1'b0, 1'b0, 1'b1, GL, 1, "R1 final write");

    done = 1'b1;
    finish_run();
  end
endmodule